// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block is the command-issue stage of a single-data-rate SDRAM controller. It takes an in-order stream of read and write requests and produces the chip-select, row/column strobes, write enable, bank and column address, the data mask and the controller's data-bus drive. Every row is taken as already open, so only READ, WRITE and NOP are ever issued. A request stays on the request lines until the cycle in which `req_ready` is high.

A WRITE may follow a READ before that READ's burst has finished returning data. The sequencer knows which cycles still carry read beats. Ahead of such a truncating WRITE it raises the data mask so that the last due beat is suppressed, and it lets the WRITE cut off the rest of the burst. When `cfg_gap` is set, the mask window is one cycle longer. This leaves a quiet bus cycle between the final read beat and the first write word, for systems where the controller's drivers may turn on before the memory releases the bus. Read beats that actually arrive are reported on `rd_valid`/`rd_data`.

Top module: `sdr_rdwr_seq`

## Requirements
- R1: Commands use active-low pins with `sd_cs_n` low. NOP is ras/cas/we = 1/1/1, READ is 1/0/1 and WRITE is 1/0/0. During a READ or WRITE, `sd_ba` and `sd_addr` carry the request's bank and column.
- R2: While reset is held, the outputs show a NOP, with `sd_dqm`, `sd_dq_oe` and `rd_valid` low.
- R3: The memory presents beat k of a READ issued in cycle n in cycle n+3+k, from column (col+k) mod 2^COLW, unless that beat was cancelled. The block reports each presented beat on `rd_valid`/`rd_data` in the following cycle.
- R4: Commands leave in request order, and a request is accepted in the cycle before its command appears. A command follows a READ or WRITE by at least BURST cycles, except that a WRITE may follow a READ sooner.
- R5: A WRITE in cycle w drives `sd_dq_oe` high in cycles w to w+BURST-1, with word k = `req_wdata[k*DW +: DW]`. `sd_dqm` is low in all of those cycles. `sd_dq_oe` is low at all other times.
- R6: If read beats are still due in cycle w or later when a WRITE is issued in cycle w, then `sd_dqm` is high in cycles w-2 and w-1. The beat due in cycle w is masked (the memory suppresses a beat two cycles after it samples the mask high), beats after w are cut off, and none of them is reported.
- R7: With `cfg_gap` = 1, a truncating WRITE in cycle w also has `sd_dqm` high in cycle w-3, and no read beat is presented in cycle w-1.
- R8: `sd_dq_oe` is never high in a cycle in which an unmasked read beat is presented.
- R9: A write presented while no read beat is still due is accepted in the same cycle and issued in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gap | input | 1 | Add an idle bus cycle before a truncating write |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_bank | input | BAW | Request bank |
| req_col | input | COLW | Request start column |
| req_wdata | input | BURST*DW | Write burst, word 0 in the low bits |
| req_ready | output | 1 | Request accepted this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BAW | Bank address |
| sd_addr | output | COLW | Column address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | DW | Write data to the bus |
| sd_dq_oe | output | 1 | Controller drives the data bus |
| sd_dq_in | input | DW | Data from the bus |
| rd_valid | output | 1 | Read beat captured |
| rd_data | output | DW | Captured read beat |

## Verification
After acceptance a command appears one cycle later, and its write words appear from that same command cycle onward. A read beat is presented three cycles after its READ and is reported one cycle after that. The bench's memory model has a per-cycle schedule of due beats and a three-cycle history of the mask pin, and checks every output in the cycle where it is due, halfway through that cycle. A WRITE clears the schedule, and a beat counts as presented only if the mask two cycles earlier was low. The bench checks the mask window and the idle cycle at each WRITE that found beats still scheduled.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_MASK = 2'd2
  } sched_st_e;

  // {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_pins(sdr_cmd_e c);
    case (c)
      CMD_READ:  cmd_pins = 3'b101;
      CMD_WRITE: cmd_pins = 3'b100;
      default:   cmd_pins = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/sdr_rst_sync.sv
module sdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/sdr_cmd_sched.sv
module sdr_cmd_sched
  import sdr_seq_pkg::*;
#(
  parameter int COLW  = 8,
  parameter int BAW   = 2,
  parameter int BURST = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_gap,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [BAW-1:0]  req_bank,
  input  logic [COLW-1:0] req_col,
  input  logic            beat_late,
  input  logic            beat_live,
  output logic            req_ready,
  output logic            issue_rd,
  output logic            issue_wr,
  output sdr_cmd_e        cmd_q,
  output logic [BAW-1:0]  ba_q,
  output logic [COLW-1:0] addr_q,
  output logic            dqm_q
);
  localparam int CW = $clog2(BURST + 3);

  sched_st_e       st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            after_rd_q, after_rd_d;
  sdr_cmd_e        cmd_d;
  logic [BAW-1:0]  ba_d;
  logic [COLW-1:0] addr_d;
  logic            dqm_d;
  logic            take_rd, take_wr, fast_ok;
  logic [CW-1:0]   mask_cnt;

  // A write may go at once only when no beat is due from the next cycle
  // on, and, with the gap option, none is on the bus right now.
  assign fast_ok  = !beat_late && !(cfg_gap && beat_live);
  assign mask_cnt = cfg_gap ? CW'(2) : CW'(1);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    after_rd_d = after_rd_q;
    cmd_d      = CMD_NOP;
    ba_d       = ba_q;
    addr_d     = addr_q;
    dqm_d      = 1'b0;
    take_rd    = 1'b0;
    take_wr    = 1'b0;
    case (st_q)
      ST_MASK: begin
        if (cnt_q != '0) begin
          dqm_d = 1'b1;
          cnt_d = cnt_q - CW'(1);
        end else if (req_valid && req_write) begin
          take_wr = 1'b1;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        if (st_q == ST_GAP) begin
          cnt_d = cnt_q - CW'(1);
          if (cnt_q <= CW'(1)) st_d = ST_IDLE;
        end
        if (req_valid && (st_q == ST_IDLE || (after_rd_q && req_write))) begin
          if (!req_write)   take_rd = 1'b1;
          else if (fast_ok) take_wr = 1'b1;
          else begin
            st_d  = ST_MASK;
            cnt_d = mask_cnt;
            dqm_d = 1'b1;
          end
        end
      end
    endcase
    if (take_rd || take_wr) begin
      cmd_d      = take_rd ? CMD_READ : CMD_WRITE;
      ba_d       = req_bank;
      addr_d     = req_col;
      after_rd_d = take_rd;
      st_d       = (BURST > 1) ? ST_GAP : ST_IDLE;
      cnt_d      = CW'(BURST - 1);
    end
  end

  assign req_ready = take_rd || take_wr;
  assign issue_rd  = take_rd;
  assign issue_wr  = take_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      after_rd_q <= 1'b0;
      cmd_q      <= CMD_NOP;
      ba_q       <= '0;
      addr_q     <= '0;
      dqm_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      after_rd_q <= after_rd_d;
      cmd_q      <= cmd_d;
      dqm_q      <= dqm_d;
      if (take_rd || take_wr) begin
        ba_q   <= ba_d;
        addr_q <= addr_d;
      end
    end
  end

  // R4: while the mask window is still counting, no request is taken
  a_r4_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MASK && cnt_q != '0) |-> !req_ready);
endmodule

// File: rtl/sdr_rd_track.sv
module sdr_rd_track #(
  parameter int DW      = 16,
  parameter int CAS_LAT = 3,
  parameter int BURST   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_rd,
  input  logic          issue_wr,
  input  logic          dqm_now,
  input  logic [DW-1:0] dq_in,
  output logic          beat_live,
  output logic          beat_late,
  output logic          dqm_prev,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = CAS_LAT + BURST;

  logic [DEPTH-1:0] beat_q, beat_d;
  logic             dqm_p1_q, dqm_p2_q;
  logic             rd_valid_q;
  logic [DW-1:0]    rd_data_q;

  // beat_q[i]: a read beat is due i cycles from now
  always_comb begin
    beat_d = beat_q >> 1;
    if (issue_rd) begin
      for (int k = 0; k < BURST; k++) beat_d[CAS_LAT + k] = 1'b1;
    end
    if (issue_wr) beat_d = '0;
  end

  assign beat_live = beat_q[0] && !dqm_p2_q;
  assign beat_late = |beat_q[DEPTH-1:1];
  assign dqm_prev  = dqm_p1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q     <= '0;
      dqm_p1_q   <= 1'b0;
      dqm_p2_q   <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      beat_q     <= beat_d;
      dqm_p1_q   <= dqm_now;
      dqm_p2_q   <= dqm_p1_q;
      rd_valid_q <= beat_live;
      if (beat_live) rd_data_q <= dq_in;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/sdr_wr_drive.sv
module sdr_wr_drive #(
  parameter int DW    = 16,
  parameter int BURST = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_wr,
  input  logic [BURST*DW-1:0] wdata,
  output logic                dq_oe,
  output logic [DW-1:0]       dq_out
);
  localparam int LW = $clog2(BURST + 1);

  logic [BURST*DW-1:0] buf_q, buf_d;
  logic [LW-1:0]       left_q, left_d;
  logic                oe_q, oe_d;
  logic [DW-1:0]       out_q, out_d;

  always_comb begin
    buf_d  = buf_q;
    left_d = left_q;
    oe_d   = 1'b0;
    out_d  = out_q;
    if (issue_wr) begin
      out_d  = wdata[DW-1:0];
      buf_d  = wdata >> DW;
      left_d = LW'(BURST - 1);
      oe_d   = 1'b1;
    end else if (left_q != '0) begin
      out_d  = buf_q[DW-1:0];
      buf_d  = buf_q >> DW;
      left_d = left_q - LW'(1);
      oe_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      left_q <= '0;
      oe_q   <= 1'b0;
      out_q  <= '0;
    end else begin
      left_q <= left_d;
      oe_q   <= oe_d;
      if (oe_d) begin
        buf_q <= buf_d;
        out_q <= out_d;
      end
    end
  end

  assign dq_oe  = oe_q;
  assign dq_out = out_q;
endmodule

// File: rtl/sdr_rdwr_seq.sv
module sdr_rdwr_seq
  import sdr_seq_pkg::*;
#(
  parameter int DW      = 16,
  parameter int COLW    = 8,
  parameter int BAW     = 2,
  parameter int CAS_LAT = 3,
  parameter int BURST   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_gap,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [BAW-1:0]      req_bank,
  input  logic [COLW-1:0]     req_col,
  input  logic [BURST*DW-1:0] req_wdata,
  output logic                req_ready,
  output logic                sd_cs_n,
  output logic                sd_ras_n,
  output logic                sd_cas_n,
  output logic                sd_we_n,
  output logic [BAW-1:0]      sd_ba,
  output logic [COLW-1:0]     sd_addr,
  output logic                sd_dqm,
  output logic [DW-1:0]       sd_dq_out,
  output logic                sd_dq_oe,
  input  logic [DW-1:0]       sd_dq_in,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data
);
  logic     rst_s_n;
  logic     issue_rd, issue_wr;
  logic     beat_live, beat_late, dqm_prev;
  sdr_cmd_e cmd_q;

  sdr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  sdr_cmd_sched #(.COLW(COLW), .BAW(BAW), .BURST(BURST)) u_sched (
    .clk(clk), .rst_n(rst_s_n), .cfg_gap(cfg_gap),
    .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_col(req_col),
    .beat_late(beat_late), .beat_live(beat_live),
    .req_ready(req_ready), .issue_rd(issue_rd), .issue_wr(issue_wr),
    .cmd_q(cmd_q), .ba_q(sd_ba), .addr_q(sd_addr), .dqm_q(sd_dqm)
  );

  sdr_rd_track #(.DW(DW), .CAS_LAT(CAS_LAT), .BURST(BURST)) u_track (
    .clk(clk), .rst_n(rst_s_n), .issue_rd(issue_rd), .issue_wr(issue_wr),
    .dqm_now(sd_dqm), .dq_in(sd_dq_in),
    .beat_live(beat_live), .beat_late(beat_late), .dqm_prev(dqm_prev),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  sdr_wr_drive #(.DW(DW), .BURST(BURST)) u_wr (
    .clk(clk), .rst_n(rst_s_n), .issue_wr(issue_wr), .wdata(req_wdata),
    .dq_oe(sd_dq_oe), .dq_out(sd_dq_out)
  );

  assign sd_cs_n = 1'b0;
  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins(cmd_q);

  // R8: the controller never drives while an unmasked beat is on the bus
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(sd_dq_oe && beat_live));

  // R6: a write that cuts a burst has the mask high on the two prior cycles
  a_r6_mask_ahead: assert property (@(posedge clk) disable iff (!rst_s_n)
    (issue_wr && beat_late) |-> (sd_dqm && dqm_prev));

  // R7: with the gap option, the cycle before the write is quiet
  a_r7_quiet_cycle: assert property (@(posedge clk) disable iff (!rst_s_n)
    (issue_wr && cfg_gap) |-> !beat_live);

  // R5: write words are never masked
  a_r5_write_unmasked: assert property (@(posedge clk) disable iff (!rst_s_n)
    sd_dq_oe |-> !sd_dqm);
endmodule

// File: tb/sdr_rdwr_seq_bench.sv
module sdr_rdwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16, COLW = 8, BAW = 2, CL = 3, BURST = 4;
  localparam int AW = BAW + COLW;

  logic clk = 1'b0, rst_n = 1'b0, cfg_gap = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [BAW-1:0] req_bank = '0;
  logic [COLW-1:0] req_col = '0;
  logic [BURST*DW-1:0] req_wdata = '0;
  logic [DW-1:0] dq_in = '0;
  logic req_ready, cs_n, ras_n, cas_n, we_n, dqm, dq_oe, rd_valid;
  logic [BAW-1:0] ba;
  logic [COLW-1:0] addr;
  logic [DW-1:0] dq_out, rd_data;

  sdr_rdwr_seq #(.DW(DW), .COLW(COLW), .BAW(BAW), .CAS_LAT(CL), .BURST(BURST))
  u_sdr_rdwr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap), .req_valid(req_valid),
    .req_write(req_write), .req_bank(req_bank), .req_col(req_col),
    .req_wdata(req_wdata), .req_ready(req_ready), .sd_cs_n(cs_n),
    .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba),
    .sd_addr(addr), .sd_dqm(dqm), .sd_dq_out(dq_out), .sd_dq_oe(dq_oe),
    .sd_dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0, mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 40503 + 23130);
  endfunction

  // bench memory model and request log
  logic [DW-1:0] mem [0:(1<<AW)-1];
  bit q_w [0:1023];
  logic [BAW-1:0] q_b [0:1023];
  logic [COLW-1:0] q_c [0:1023];
  logic [BURST*DW-1:0] q_d [0:1023];
  int q_in = 0, q_out = 0;
  bit sv [0:15];
  logic [AW-1:0] sa [0:15];

  // monitor: one pass per cycle, halfway through it
  initial begin
    int cyc = 0, last_cmd = -100, wleft = 0;
    bit last_rd = 0, exp_rv = 0, arr_last = 0;
    bit d1 = 0, d2 = 0, d3 = 0;
    logic [DW-1:0] exp_rd = '0;
    logic [BURST*DW-1:0] wbuf = '0;
    for (int i = 0; i < (1<<AW); i++) mem[i] = init_word(i);
    for (int i = 0; i < 16; i++) sv[i] = 0;
    wait (mon_on);
    forever begin
      bit is_rd, is_wr, trunc, arr;
      int slot;
      @(negedge clk);
      cyc++;
      is_rd = !cs_n && ras_n && !cas_n && we_n;
      is_wr = !cs_n && ras_n && !cas_n && !we_n;
      chk(is_rd || is_wr || (!cs_n && ras_n && cas_n && we_n), "R1 legal command",
          {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      chk(rd_valid == exp_rv, "R3 rd_valid", rd_valid, exp_rv);
      if (exp_rv) chk(rd_data == exp_rd, "R3 rd_data", rd_data, exp_rd);
      if (is_rd || is_wr) begin
        chk(q_out < q_in && q_w[q_out] == is_wr, "R4 command order", is_wr, q_w[q_out]);
        chk(ba == q_b[q_out] && addr == q_c[q_out], "R1 bank/column",
            {ba, addr}, {q_b[q_out], q_c[q_out]});
        chk((cyc - last_cmd >= BURST) || (is_wr && last_rd), "R4 spacing",
            cyc - last_cmd, BURST);
      end
      if (is_wr) begin
        trunc = 0;
        for (int i = 0; i < 16; i++) if (sv[i]) trunc = 1;
        if (trunc) chk(d1 && d2, "R6 mask before truncating write", {d2, d1}, 2'b11);
        if (trunc && cfg_gap) chk(d3, "R7 longer mask window", d3, 1);
        if (cfg_gap) chk(!arr_last, "R7 quiet cycle before write", arr_last, 0);
        chk(!dqm, "R5 mask low at write", dqm, 0);
        for (int i = 0; i < 16; i++) sv[i] = 0;
        wbuf = q_d[q_out];
        wleft = BURST;
        for (int k = 0; k < BURST; k++)
          mem[{q_b[q_out], COLW'(q_c[q_out] + COLW'(k))}] = q_d[q_out][k*DW +: DW];
      end
      if (is_rd) begin
        for (int k = 0; k < BURST; k++) begin
          sv[(cyc + CL + k) % 16] = 1;
          sa[(cyc + CL + k) % 16] = {q_b[q_out], COLW'(q_c[q_out] + COLW'(k))};
        end
      end
      if (is_rd || is_wr) begin
        last_cmd = cyc; last_rd = is_rd; q_out++;
      end
      if (wleft > 0) begin
        chk(dq_oe && !dqm, "R5 write word drive", {dq_oe, dqm}, 2'b10);
        chk(dq_out == wbuf[DW-1:0], "R5 write word", dq_out, wbuf[DW-1:0]);
        wbuf = wbuf >> DW;
        wleft--;
      end else begin
        chk(!dq_oe, "R5 no drive outside write", dq_oe, 0);
      end
      slot = cyc % 16;
      arr = sv[slot] && !d2;
      if (arr) chk(!dq_oe, "R8 no contention", dq_oe, 0);
      dq_in = arr ? mem[sa[slot]] : ~mem[sa[slot]];
      exp_rv = arr;
      exp_rd = mem[sa[slot]];
      sv[slot] = 0;
      arr_last = arr;
      if (req_valid && req_ready) begin
        q_w[q_in] = req_write; q_b[q_in] = req_bank;
        q_c[q_in] = req_col; q_d[q_in] = req_wdata;
        q_in++;
      end
      d3 = d2; d2 = d1; d1 = dqm;
    end
  end

  task automatic send(input bit w, input logic [BAW-1:0] b, input logic [COLW-1:0] c);
    req_valid = 1; req_write = w; req_bank = b; req_col = c;
    req_wdata = {$urandom, $urandom};
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    repeat (20) @(posedge clk);
    #1;
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++)
      send(($urandom % 2) == 1, BAW'($urandom), COLW'($urandom % 12));
  endtask

  task automatic quick_write();  // R9
    req_valid = 1; req_write = 1; req_bank = 2'd1; req_col = 8'd5;
    req_wdata = {$urandom, $urandom};
    @(negedge clk);
    chk(req_ready, "R9 immediate write accept", req_ready, 1);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cs_n == 0 && {ras_n, cas_n, we_n} == 3'b111, "R2 reset NOP",
        {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk(!dqm && !dq_oe && !rd_valid, "R2 reset quiet", {dqm, dq_oe, rd_valid}, 0);
    @(posedge clk); #1;
    rst_n = 1;
    repeat (4) @(posedge clk); #1;
    mon_on = 1;
    cfg_gap = 0;
    send(0, 2'd0, 8'd0); send(1, 2'd0, 8'd2);   // truncating write
    send(0, 2'd0, 8'd0);                         // reads back merged data
    send(1, 2'd1, 8'd4); send(1, 2'd1, 8'd8);   // write after write
    drain(); quick_write(); drain();
    random_run(150);
    drain();
    cfg_gap = 1;
    send(0, 2'd2, 8'd1); send(1, 2'd2, 8'd3);
    send(0, 2'd2, 8'd1); send(0, 2'd3, 8'd0);
    drain(); quick_write(); drain();
    random_run(150);
    drain();
    done = 1;
  end

  initial begin
    int t = 0;
    while (!done && t < 20000) begin
      @(posedge clk);
      t++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", t);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule